// File: doc/BRIEF.md
# Interval Timer with Interrupt Routing

This block pairs a 12-bit down-counting interval timer with a small interrupt unit. The CPU programs a reload value, and the timer then counts ticks from one of two sources: a fast system tick or the horizontal line-sync pulse. Each time the count runs out, the timer raises a one-cycle event and reloads itself from the programmed value. Software does not need to act between periods.

The timer event and five peripheral event pulses feed two independent pending banks. Peripheral events cover horizontal border, vertical border, serial data, keyboard and cartridge. One bank drives a normal interrupt request (`irq`) and the other drives a fast interrupt request (`firq`). Each bank has its own enable register and a chip-level master enable. Software reads a bank's register to collect and clear its pending flags.

The CPU reaches the block through a single-cycle register port. Writes take effect at the clock edge. A read returns its data on `rd_data` one cycle after `rd_en`.

Top module: `ivt_irq_top`

## Requirements
- R1: After synchronous reset, `irq`, `firq` and `rd_data` are 0, all pending flags are clear, and the timer is stopped.
- R2: A write to the count-high register (address 3, value in bits 3:0) only stages the upper 4 count bits. The running count and its period do not change.
- R3: A write to the count-low register (address 4) loads the reload value {staged nibble, byte} and restarts the count from it. A tick in the same cycle is ignored.
- R4: With clock select 0 (control bit 2), a loaded value N gives a timer event on every N-th fast tick. Line ticks have no effect, and the count reloads by itself.
- R5: With clock select 1, only line ticks are counted, and fast ticks have no effect.
- R6: A loaded value of zero stops the timer, and no timer events occur.
- R7: Both enable registers (IRQ at address 1, FIRQ at address 2) use this layout: bit 5 timer, bit 4 horizontal border, bit 3 vertical border, bit 2 serial, bit 1 keyboard, bit 0 cartridge. An event sets a bank's pending flag only when that bank's enable bit is 1 at that moment. The two banks act independently.
- R8: A read of address 1 (or 2) returns that bank's pending flags in bits 5:0 on the next cycle and clears them. An event in the read cycle stays pending.
- R9: `irq` is 1 exactly when control bit 0 is 1 and some IRQ pending flag has its enable bit set. `firq` follows the same rule using control bit 1 and the FIRQ bank. Clearing an enable bit masks the output but keeps the flag readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0 control, 1 IRQ enable, 2 FIRQ enable, 3 count high, 4 count low |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| fast_tick | input | 1 | Fast count tick pulse |
| line_tick | input | 1 | Horizontal sync tick pulse |
| hbord_evt | input | 1 | Horizontal border event pulse |
| vbord_evt | input | 1 | Vertical border event pulse |
| ser_evt | input | 1 | Serial data event pulse |
| kbd_evt | input | 1 | Keyboard event pulse |
| cart_evt | input | 1 | Cartridge event pulse |
| irq | output | 1 | Normal interrupt request, active high |
| firq | output | 1 | Fast interrupt request, active high |

## Verification
The bound checker watches several rules on every cycle:
- Both request outputs go quiet after reset.
- A request never appears while its master enable is off.
- A stopped timer never fires, and a load cycle never coincides with a timer event.
- A read with no concurrent event leaves the IRQ bank empty.
- Every enabled event lands in the IRQ bank.

Only the bench scenarios can show the actual timer periods, for both tick sources and across a multi-nibble reload. They also show that the staged nibble leaves the running period alone, that bit positions map to the right sources, and that an event arriving during a clearing read survives it.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int CNT_W  = 12;
    localparam int LO_W   = 8;
    localparam int HI_W   = CNT_W - LO_W;
    localparam int NSRC   = 6;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    // source bit positions, shared by both enable registers
    localparam int SRC_CART = 0;
    localparam int SRC_KBD  = 1;
    localparam int SRC_SER  = 2;
    localparam int SRC_VB   = 3;
    localparam int SRC_HB   = 4;
    localparam int SRC_TMR  = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_IEN  = 3'd1,
        A_FEN  = 3'd2,
        A_CHI  = 3'd3,
        A_CLO  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic clk_sel;   // 1 = line sync tick
        logic firq_on;
        logic irq_on;
    } ctrl_t;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [CNT_W-1:0] count_t;

    function automatic count_t join_count(input logic [HI_W-1:0] hi,
                                          input logic [LO_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic src_vec_t pack_sources(input logic tmr, input logic hb,
                                              input logic vb, input logic ser,
                                              input logic kbd, input logic cart);
        src_vec_t v;
        v           = '0;
        v[SRC_TMR]  = tmr;
        v[SRC_HB]   = hb;
        v[SRC_VB]   = vb;
        v[SRC_SER]  = ser;
        v[SRC_KBD]  = kbd;
        v[SRC_CART] = cart;
        return v;
    endfunction
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output src_vec_t          ien,
    output src_vec_t          fen,
    output logic [HI_W-1:0]   hi_stage,
    output logic              load,
    output count_t            load_val
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[DATA_W-1:NSRC];

    assign load     = wr_en && (addr == A_CLO);
    assign load_val = join_count(hi_stage, wr_data[LO_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            ien      <= '0;
            fen      <= '0;
            hi_stage <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:  ctrl     <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                A_IEN:   ien      <= wr_data[NSRC-1:0];
                A_FEN:   fen      <= wr_data[NSRC-1:0];
                A_CHI:   hi_stage <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fast_tick,
    input  logic   line_tick,
    input  logic   sel_line,
    input  logic   load,
    input  count_t load_val,
    output logic   evt,
    output count_t reload
);
    count_t cnt_q;
    logic   tick;
    logic   running;
    logic   last;

    assign tick    = sel_line ? line_tick : fast_tick;
    assign running = (reload != '0);
    assign last    = (cnt_q == count_t'(1));
    assign evt     = tick && running && last && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            reload <= load_val;
            cnt_q  <= load_val;
        end else if (tick && running) begin
            cnt_q  <= last ? reload : cnt_q - count_t'(1);
        end
    end
endmodule

// File: rtl/ivt_pend_bank.sv
module ivt_pend_bank
    import ivt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  src_vec_t en,
    input  logic     clr,
    input  logic     master,
    output src_vec_t pend,
    output logic     req
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else
                pend[i] <= (pend[i] && !clr) || (evt[i] && en[i]);
        end
    end

    assign req = master && |(pend & en);
endmodule

// File: rtl/ivt_irq_top.sv
module ivt_irq_top
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fast_tick,
    input  logic              line_tick,
    input  logic              hbord_evt,
    input  logic              vbord_evt,
    input  logic              ser_evt,
    input  logic              kbd_evt,
    input  logic              cart_evt,
    output logic              irq,
    output logic              firq
);
    ctrl_t           ctrl;
    src_vec_t        ien, fen, irq_pend, firq_pend, evt_vec;
    logic [HI_W-1:0] hi_stage;
    logic            load, tmr_evt;
    count_t          load_val, tmr_reload;
    logic            irq_master, firq_master;

    assign irq_master  = ctrl.irq_on;
    assign firq_master = ctrl.firq_on;

    ivt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .ctrl(ctrl), .ien(ien), .fen(fen), .hi_stage(hi_stage),
        .load(load), .load_val(load_val)
    );

    ivt_timer u_timer (
        .clk(clk), .rst(rst), .fast_tick(fast_tick), .line_tick(line_tick),
        .sel_line(ctrl.clk_sel), .load(load), .load_val(load_val),
        .evt(tmr_evt), .reload(tmr_reload)
    );

    assign evt_vec = pack_sources(tmr_evt, hbord_evt, vbord_evt,
                                  ser_evt, kbd_evt, cart_evt);

    ivt_pend_bank u_irq_bank (
        .clk(clk), .rst(rst), .evt(evt_vec), .en(ien),
        .clr(rd_en && (addr == A_IEN)), .master(irq_master),
        .pend(irq_pend), .req(irq)
    );

    ivt_pend_bank u_firq_bank (
        .clk(clk), .rst(rst), .evt(evt_vec), .en(fen),
        .clr(rd_en && (addr == A_FEN)), .master(firq_master),
        .pend(firq_pend), .req(firq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (addr)
                A_CTRL:  rd_data <= DATA_W'(ctrl);
                A_IEN:   rd_data <= DATA_W'(irq_pend);
                A_FEN:   rd_data <= DATA_W'(firq_pend);
                A_CHI:   rd_data <= DATA_W'(hi_stage);
                default: rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ivt_irq_top_chk.sv
module ivt_irq_top_chk
    import ivt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic              firq,
    input logic              irq_master,
    input logic              firq_master,
    input src_vec_t          evt_vec,
    input src_vec_t          ien,
    input src_vec_t          irq_pend,
    input count_t            tmr_reload,
    input logic              tmr_evt
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && !firq));

    // R9
    irq_master_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_master);

    // R9
    firq_master_chk: assert property (@(posedge clk) disable iff (rst)
        firq |-> firq_master);

    // R6
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_reload == '0) |-> !tmr_evt);

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CLO) |-> !tmr_evt);

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_IEN && evt_vec == '0) |=> (irq_pend == '0));

    // R7
    latch_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt_vec & ien) != '0) |=>
            ((irq_pend & $past(evt_vec & ien)) == $past(evt_vec & ien)));
endmodule

bind ivt_irq_top ivt_irq_top_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .irq(irq), .firq(firq), .irq_master(irq_master), .firq_master(firq_master),
    .evt_vec(evt_vec), .ien(ien), .irq_pend(irq_pend),
    .tmr_reload(tmr_reload), .tmr_evt(tmr_evt)
);

// File: tb/ivt_irq_top_tb.sv
module ivt_irq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       fast_tick = 1'b0, line_tick = 1'b0;
    logic       hbord_evt = 1'b0, vbord_evt = 1'b0, ser_evt = 1'b0;
    logic       kbd_evt = 1'b0, cart_evt = 1'b0;
    logic       irq, firq;

    always #5 clk = ~clk;

    ivt_irq_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .fast_tick(fast_tick),
        .line_tick(line_tick), .hbord_evt(hbord_evt), .vbord_evt(vbord_evt),
        .ser_evt(ser_evt), .kbd_evt(kbd_evt), .cart_evt(cart_evt),
        .irq(irq), .firq(firq)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic rd_pipe = 1'b0;
    logic done = 1'b0;

    // monitor: compares each read result against the queued expectation
    always @(posedge clk) rd_pipe <= rd_en;
    always @(negedge clk) begin
        if (rd_pipe) begin
            exp_t e;
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with no expectation, actual %h expected none", rd_data);
            end else begin
                e = sb_q.pop_front();
                if (rd_data !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: rd_data actual %h expected %h", e.tag, rd_data, e.exp);
                end
            end
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp: exp, tag: tag});
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    task automatic line(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_tick = 1'b1;
            @(negedge clk); line_tick = 1'b0;
        end
    endtask

    // m = {hbord, vbord, ser, kbd, cart}
    task automatic evts(input logic [4:0] m);
        @(negedge clk);
        {hbord_evt, vbord_evt, ser_evt, kbd_evt, cart_evt} = m;
        @(negedge clk);
        {hbord_evt, vbord_evt, ser_evt, kbd_evt, cart_evt} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(irq, 0, "R1 irq after reset");
        chk(firq, 0, "R1 firq after reset");
        chk(rd_data, 8'h00, "R1 rd_data after reset");
        rd(3'd1, 8'h00, "R1 no pending after reset");

        // R4 fast tick, period 3
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h20);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h03);
        fast(2);
        chk(irq, 0, "R4 before third fast tick");
        fast(1);
        chk(irq, 1, "R4 event on third fast tick");
        rd(3'd1, 8'h20, "R8 timer pending bit 5");
        chk(irq, 0, "R8 irq dropped after clearing read");
        line(5);
        chk(irq, 0, "R4 line ticks ignored");
        fast(3);
        chk(irq, 1, "R4 automatic reload period");
        rd(3'd1, 8'h20, "R4 reload pending");

        // R2 staging leaves running period alone
        wr(3'd3, 8'h01);
        fast(3);
        chk(irq, 1, "R2 period unchanged after high write");
        rd(3'd3, 8'h01, "R2 staged nibble");
        rd(3'd1, 8'h20, "R2 clear");
        // R3 load 0x100
        wr(3'd4, 8'h00);
        fast(255);
        chk(irq, 0, "R3 before 256th tick");
        fast(1);
        chk(irq, 1, "R3 event at 256th tick");
        rd(3'd1, 8'h20, "R3 clear");

        // R5 line select
        wr(3'd0, 8'h07);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h02);
        fast(5);
        chk(irq, 0, "R5 fast ticks ignored");
        line(1);
        chk(irq, 0, "R5 before second line tick");
        line(1);
        chk(irq, 1, "R5 event on second line tick");
        rd(3'd1, 8'h20, "R5 clear");

        // R6 zero stops
        wr(3'd4, 8'h00);
        line(20);
        fast(20);
        chk(irq, 0, "R6 stopped timer silent");
        rd(3'd1, 8'h00, "R6 no timer pending");

        // R7 layout and independent banks
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h15);
        wr(3'd2, 8'h0A);
        evts(5'b11111);
        chk(irq, 1, "R7 irq from enabled sources");
        chk(firq, 1, "R7 firq from enabled sources");
        rd(3'd1, 8'h15, "R7 irq bank layout");
        chk(irq, 0, "R8 irq cleared");
        chk(firq, 1, "R8 firq bank untouched by irq read");
        rd(3'd2, 8'h0A, "R7 firq bank layout");
        chk(firq, 0, "R8 firq cleared");

        // R9 master gating and masking
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h02);
        evts(5'b00010);
        chk(firq, 0, "R9 firq held by master off");
        wr(3'd0, 8'h02);
        chk(firq, 1, "R9 firq after master on");
        chk(irq, 0, "R9 irq master still off");
        wr(3'd2, 8'h00);
        chk(firq, 0, "R9 firq masked by enable");
        rd(3'd2, 8'h02, "R9 masked flag still pending");
        rd(3'd0, 8'h02, "R9 control readback");

        // R8 event during read survives
        wr(3'd2, 8'h02);
        @(negedge clk);
        sb_q.push_back('{exp: 8'h00, tag: "R8 read during event"});
        rd_en = 1'b1; addr = 3'd2; kbd_evt = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; kbd_evt = 1'b0;
        chk(firq, 1, "R8 concurrent event kept");
        rd(3'd2, 8'h02, "R8 concurrent event readable");

        // R7 timer routed to FIRQ only
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h20);
        wr(3'd4, 8'h01);
        fast(1);
        chk(firq, 1, "R7 timer on firq");
        chk(irq, 0, "R7 timer not on irq");
        rd(3'd2, 8'h20, "R7 timer firq pending");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule